// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Array

This block evaluates a fixed mix of arithmetic terms in a single combinational pass and returns their total modulo 2^W. A term is a product of two operands, a plain addend, or a one-bit addend. Each product and addend is declared at elaboration as signed or unsigned, and as added or subtracted. Every term becomes one or more rows of W bits. Products give one AND row per multiplier bit, with a two's-complement correction on the top row of a signed multiplier. Subtracted rows are inverted, and each inversion owes a single 1 at weight 2^0. These owed 1s and the one-bit addends are gathered as loose bits. A tree of 3:2 compressor layers reduces all rows to two words. The loose bits go into the free bit 0 of each carry word and into the carry input of the single final adder. If there are more loose bits than free positions, the surplus becomes extra rows.

The array sits behind a valid/ready stream stage. With `OUT_REG=1`, one result register separates the array from the output. A beat is accepted when `in_valid && in_ready`, where `in_ready = !out_valid || out_ready`. The registered result stays stable while `out_valid` is high and `out_ready` is low. With `OUT_REG=0`, the stage is a wire: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the result follows the inputs in the same cycle.

Top module: `mac_array`

## Requirements
- R1: Operand k of a packed port occupies bits [k*width +: width]. An unsigned product term contributes (A_k zero-extended × B_k zero-extended) mod 2^W.
- R2: A product whose `P_SIGNED` bit is 1 treats both operands as two's complement. This includes the most negative values, for example -128 × -128 = 16384.
- R3: A product or addend whose subtract bit (`P_SUB`, `A_SUB`) is 1 is subtracted from the total, not added.
- R4: An addend is sign-extended to W when its `A_SIGNED` bit is 1 and zero-extended otherwise. Addend bits above W are discarded.
- R5: Each bit of `bit_add` adds 1 at weight 2^0, independently of the others.
- R6: The result equals the exact mathematical total reduced modulo 2^W. Carries beyond bit W-1 are lost.
- R7: When every operand, addend and bit addend is zero, the result is zero, whatever the sign and subtract settings.
- R8: With `OUT_REG=1`, while `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `result` keeps its value on the next cycle.
- R9: With `OUT_REG=1`, `in_ready = !out_valid || out_ready`, and an accepted beat raises `out_valid` in the next cycle with its result. With `OUT_REG=0`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R10: With `OUT_REG=1`, `out_valid` is 0 after any clock edge during which `rst_n` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Beat can be taken this cycle |
| prod_a | input | NP*AW | Multiplicands, operand k in [k*AW +: AW] |
| prod_b | input | NP*BW | Multipliers, operand k in [k*BW +: BW] |
| addend | input | NA*DW | Addends, addend k in [k*DW +: DW] |
| bit_add | input | NB | One-bit addends, each of weight 1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | W | Sum modulo 2^W |

## Verification
The bench builds two instances. The first uses the default set: W=16, two 8×8 products (one unsigned and added, one signed and subtracted), two 12-bit addends (one signed and added, one unsigned and subtracted), two bit addends and the output register. This exercises the signed top-row correction, the subtract inversion and the registered handshake under back-pressure. The second is narrow and combinational: W=10, one signed and subtracted 8×6 product, one unsigned 12-bit addend wider than W, and three bit addends. There the loose bits outnumber the free tree positions, so surplus rows are created, and truncation of both products and addends above W is reached.

// File: rtl/mac_pkg.sv
package mac_pkg;

  function automatic int pop32(input logic [31:0] v);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  // rows before spilling: one per multiplier bit, plus one per signed product, plus addends
  function automatic int base_rows(input int np, input int bw, input int na, input logic [31:0] psg);
    return np * bw + pop32(psg) + na;
  endfunction

  // owed ones from inverted rows
  function automatic int owed_ones(input int bw, input logic [31:0] psg,
                                   input logic [31:0] psub, input logic [31:0] asub);
    int c;
    c = pop32(asub);
    for (int i = 0; i < 32; i++)
      if (psub[i]) c += bw + int'(psg[i]);
    return c;
  endfunction

  // surplus loose bits turned into rows so that loose <= rows - 1
  function automatic int spill_rows(input int loose, input int r0);
    return (loose >= r0) ? (loose - r0 + 2) / 2 : 0;
  endfunction

  function automatic int next_rows(input int n);
    return 2 * (n / 3) + n % 3;
  endfunction

  function automatic int tree_depth(input int r);
    int n, l;
    n = r;
    l = 0;
    while (n > 2) begin
      n = next_rows(n);
      l++;
    end
    return l;
  endfunction

  function automatic int rows_at(input int r, input int l);
    int n;
    n = r;
    for (int k = 0; k < l; k++) n = next_rows(n);
    return n;
  endfunction

  function automatic int groups_before(input int r, input int l);
    int n, g;
    n = r;
    g = 0;
    for (int k = 0; k < l; k++) begin
      g += n / 3;
      n = next_rows(n);
    end
    return g;
  endfunction

endpackage

// File: rtl/mac_csa.sv
module mac_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         fill_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] maj;

  assign sum_o   = x_i ^ y_i ^ z_i;
  assign maj     = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  // carry moves up one weight; the top carry falls off, bit 0 takes a loose bit
  assign carry_o = {maj[W-2:0], fill_i};
endmodule

// File: rtl/mac_rows.sv
module mac_rows #(
  parameter int W      = 16,
  parameter int NP     = 2,
  parameter int AW     = 8,
  parameter int BW     = 8,
  parameter int NA     = 2,
  parameter int DW     = 12,
  parameter int NB     = 2,
  parameter logic [NP-1:0] P_SIGNED = '0,
  parameter logic [NP-1:0] P_SUB    = '0,
  parameter logic [NA-1:0] A_SIGNED = '0,
  parameter logic [NA-1:0] A_SUB    = '0,
  parameter int R0     = 1,
  parameter int NLOOSE = 1,
  parameter int NSPILL = 0,
  parameter int R      = R0 + NSPILL,
  parameter int NSLOT  = NLOOSE - NSPILL
) (
  input  logic [NP*AW-1:0] prod_a,
  input  logic [NP*BW-1:0] prod_b,
  input  logic [NA*DW-1:0] addend,
  input  logic [NB-1:0]    bit_add,
  output logic [R*W-1:0]   rows_o,
  output logic [R-1:0]     slots_o
);
  localparam int LW = (NLOOSE > 0) ? NLOOSE : 1;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] rw [R];
  logic [LW-1:0] loose;

  always_comb begin
    int r;
    int k;
    logic [W-1:0] ea;
    logic [W-1:0] v;
    logic bi;
    for (int j = 0; j < R; j++) rw[j] = '0;
    loose = '0;
    r = 0;
    k = NB;
    ea = '0;
    v = '0;
    bi = 1'b0;
    for (int j = 0; j < NB; j++) loose[j] = bit_add[j];
    for (int p = 0; p < NP; p++) begin
      for (int q = 0; q < W; q++) begin
        int qi;
        qi = (q < AW) ? q : AW - 1;
        ea[q] = (q < AW) ? prod_a[p*AW+qi] : (P_SIGNED[p] & prod_a[p*AW+AW-1]);
      end
      for (int i = 0; i < BW; i++) begin
        bi = prod_b[p*BW+i];
        if (P_SIGNED[p] && i == BW - 1) begin
          // top multiplier bit has negative weight: ~A shifted, plus the bit itself
          v = ~(ea << i) & (ONES << i) & {W{bi}};
          rw[r] = P_SUB[p] ? ~v : v;
          r++;
          v = {{(W-1){1'b0}}, bi} << i;
          rw[r] = P_SUB[p] ? ~v : v;
          r++;
          if (P_SUB[p]) begin
            loose[k] = 1'b1;
            loose[k+1] = 1'b1;
            k += 2;
          end
        end else begin
          v = (ea << i) & {W{bi}};
          rw[r] = P_SUB[p] ? ~v : v;
          r++;
          if (P_SUB[p]) begin
            loose[k] = 1'b1;
            k++;
          end
        end
      end
    end
    for (int d = 0; d < NA; d++) begin
      for (int q = 0; q < W; q++) begin
        int qi;
        qi = (q < DW) ? q : DW - 1;
        v[q] = (q < DW) ? addend[d*DW+qi] : (A_SIGNED[d] & addend[d*DW+DW-1]);
      end
      rw[r] = A_SUB[d] ? ~v : v;
      r++;
      if (A_SUB[d]) begin
        loose[k] = 1'b1;
        k++;
      end
    end
    for (int x = 0; x < NSPILL; x++)
      rw[R0+x] = {{(W-1){1'b0}}, loose[NSLOT+x]};
    for (int j = 0; j < R; j++) begin
      int jc;
      jc = (j < LW) ? j : 0;
      rows_o[j*W +: W] = rw[j];
      slots_o[j] = (j < NSLOT) ? loose[jc] : 1'b0;
    end
  end
endmodule

// File: rtl/mac_tree.sv
module mac_tree
  import mac_pkg::*;
#(
  parameter int W = 16,
  parameter int R = 3
) (
  input  logic [R*W-1:0] rows_i,
  input  logic [R-1:0]   slots_i,
  output logic [W-1:0]   sum_o
);
  localparam int NL = tree_depth(R);

  logic [W-1:0] lay [NL+1][R];

  for (genvar j = 0; j < R; j++) begin : g_in
    assign lay[0][j] = rows_i[j*W +: W];
  end

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam int N  = rows_at(R, l);
    localparam int G  = N / 3;
    localparam int GB = groups_before(R, l);
    localparam int NN = rows_at(R, l + 1);
    for (genvar g = 0; g < G; g++) begin : g_grp
      mac_csa #(.W(W)) u_csa (
        .x_i    (lay[l][3*g]),
        .y_i    (lay[l][3*g+1]),
        .z_i    (lay[l][3*g+2]),
        .fill_i (slots_i[GB+g]),
        .sum_o  (lay[l+1][2*g]),
        .carry_o(lay[l+1][2*g+1])
      );
    end
    for (genvar j = 3*G; j < N; j++) begin : g_pass
      assign lay[l+1][2*G+j-3*G] = lay[l][j];
    end
    for (genvar j = NN; j < R; j++) begin : g_zero
      assign lay[l+1][j] = '0;
    end
  end

  if (R == 1) begin : g_single
    assign sum_o = lay[0][0];
  end else begin : g_cpa
    // last loose bit enters as carry-in of the one carry-propagate adder
    assign sum_o = lay[NL][0] + lay[NL][1] + {{(W-1){1'b0}}, slots_i[R-2]};
  end
endmodule

// File: rtl/mac_array.sv
module mac_array
  import mac_pkg::*;
#(
  parameter int W       = 16,
  parameter int NP      = 2,
  parameter int AW      = 8,
  parameter int BW      = 8,
  parameter int NA      = 2,
  parameter int DW      = 12,
  parameter int NB      = 2,
  parameter logic [NP-1:0] P_SIGNED = 2'b10,
  parameter logic [NP-1:0] P_SUB    = 2'b10,
  parameter logic [NA-1:0] A_SIGNED = 2'b01,
  parameter logic [NA-1:0] A_SUB    = 2'b10,
  parameter bit   OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NP*AW-1:0] prod_a,
  input  logic [NP*BW-1:0] prod_b,
  input  logic [NA*DW-1:0] addend,
  input  logic [NB-1:0]    bit_add,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     result
);
  localparam int R0     = base_rows(NP, BW, NA, 32'(P_SIGNED));
  localparam int NLOOSE = NB + owed_ones(BW, 32'(P_SIGNED), 32'(P_SUB), 32'(A_SUB));
  localparam int NSPILL = spill_rows(NLOOSE, R0);
  localparam int R      = R0 + NSPILL;
  localparam int NSLOT  = NLOOSE - NSPILL;

  logic [R*W-1:0] rows;
  logic [R-1:0]   slots;
  logic [W-1:0]   sum;

  mac_rows #(
    .W(W), .NP(NP), .AW(AW), .BW(BW), .NA(NA), .DW(DW), .NB(NB),
    .P_SIGNED(P_SIGNED), .P_SUB(P_SUB), .A_SIGNED(A_SIGNED), .A_SUB(A_SUB),
    .R0(R0), .NLOOSE(NLOOSE), .NSPILL(NSPILL), .R(R), .NSLOT(NSLOT)
  ) u_rows (
    .prod_a (prod_a),
    .prod_b (prod_b),
    .addend (addend),
    .bit_add(bit_add),
    .rows_o (rows),
    .slots_o(slots)
  );

  mac_tree #(.W(W), .R(R)) u_tree (
    .rows_i (rows),
    .slots_i(slots),
    .sum_o  (sum)
  );

  if (OUT_REG) begin : g_reg
    assign in_ready = !out_valid || out_ready;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else if (in_ready) begin
        out_valid <= in_valid;
        if (in_valid) result <= sum;
      end
    end
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign result    = sum;
  end
endmodule

// File: rtl/mac_array_chk.sv
module mac_array_chk #(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result
);
  if (OUT_REG) begin : g_reg_chk
    p_reset_idle_r10: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(result));

    p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

    p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
  end
endmodule

bind mac_array mac_array_chk #(.W(W), .OUT_REG(OUT_REG)) u_mac_array_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .result   (result)
);

// File: tb/test_mac_array.sv
module test_mac_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // wide registered instance
  logic [15:0] a_pa, a_pb;
  logic [23:0] a_ad;
  logic [1:0]  a_bits;
  logic a_iv = 1'b0, a_or = 1'b0, a_ir, a_ov;
  logic [15:0] a_res;

  // narrow combinational instance
  logic [7:0]  b_pa;
  logic [5:0]  b_pb;
  logic [11:0] b_ad;
  logic [2:0]  b_bits;
  logic b_iv = 1'b0, b_or = 1'b0, b_ir, b_ov;
  logic [9:0] b_res;

  mac_array i_mac_array (
    .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir),
    .prod_a(a_pa), .prod_b(a_pb), .addend(a_ad), .bit_add(a_bits),
    .out_valid(a_ov), .out_ready(a_or), .result(a_res)
  );

  mac_array #(
    .W(10), .NP(1), .AW(8), .BW(6), .NA(1), .DW(12), .NB(3),
    .P_SIGNED(1'b1), .P_SUB(1'b1), .A_SIGNED(1'b0), .A_SUB(1'b0), .OUT_REG(1'b0)
  ) i_mac_array_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir),
    .prod_a(b_pa), .prod_b(b_pb), .addend(b_ad), .bit_add(b_bits),
    .out_valid(b_ov), .out_ready(b_or), .result(b_res)
  );

  function automatic logic [15:0] exp_a(logic [15:0] pa, logic [15:0] pb, logic [23:0] ad, logic [1:0] bits);
    longint t;
    t = longint'(pa[7:0]) * longint'(pb[7:0])
      - longint'($signed(pa[15:8])) * longint'($signed(pb[15:8]))
      + longint'($signed(ad[11:0])) - longint'(ad[23:12])
      + longint'(bits[0]) + longint'(bits[1]);
    return t[15:0];
  endfunction

  function automatic logic [9:0] exp_b(logic [7:0] pa, logic [5:0] pb, logic [11:0] ad, logic [2:0] bits);
    longint t;
    t = -(longint'($signed(pa)) * longint'($signed(pb))) + longint'(ad)
      + longint'(bits[0]) + longint'(bits[1]) + longint'(bits[2]);
    return t[9:0];
  endfunction

  function automatic logic [7:0] pick8();
    case ($urandom % 5)
      0: return 8'h80;
      1: return 8'h7F;
      2: return 8'hFF;
      3: return 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_a(input logic [15:0] pa, input logic [15:0] pb, input logic [23:0] ad,
                       input logic [1:0] bits, input string req);
    @(negedge clk);
    a_pa = pa; a_pb = pb; a_ad = ad; a_bits = bits; a_iv = 1'b1; a_or = 1'b1;
    @(negedge clk);
    chk({req, " R9 valid"}, longint'(a_ov), 1);
    chk(req, longint'(a_res), longint'(exp_a(pa, pb, ad, bits)));
    a_iv = 1'b0;
  endtask

  task automatic run_b(input logic [7:0] pa, input logic [5:0] pb, input logic [11:0] ad,
                       input logic [2:0] bits, input string req);
    @(negedge clk);
    b_pa = pa; b_pb = pb; b_ad = ad; b_bits = bits; b_iv = 1'b1; b_or = 1'b1;
    #1;
    chk(req, longint'(b_res), longint'(exp_b(pa, pb, ad, bits)));
    chk("R9 narrow valid follows", longint'(b_ov), 1);
    b_or = 1'b0;
    #1;
    chk("R9 narrow ready follows", longint'(b_ir), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] xpa, xpb, ypa, ypb;
    logic [23:0] xad, yad;
    logic [1:0]  xb, yb;
    void'($urandom(32'h5eed_2024));
    a_pa = '0; a_pb = '0; a_ad = '0; a_bits = '0;
    b_pa = '0; b_pb = '0; b_ad = '0; b_bits = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", longint'(a_ov), 0);
    rst_n = 1'b1;

    // directed corners, wide instance
    run_a(16'h0000, 16'h0000, 24'h000000, 2'b00, "R7 zero inputs");
    run_a(16'h00FF, 16'h00FF, 24'h000000, 2'b00, "R1 unsigned all-ones product");
    run_a(16'h8000, 16'h8000, 24'h000000, 2'b00, "R2 R3 most negative signed product subtracted");
    run_a(16'h7F00, 16'h8000, 24'h000000, 2'b00, "R2 mixed sign product");
    run_a(16'h0000, 16'h0000, 24'h000800, 2'b00, "R4 signed addend sign-extended");
    run_a(16'h0000, 16'h0000, 24'hFFF000, 2'b00, "R3 R4 unsigned addend subtracted");
    run_a(16'h0000, 16'h0000, 24'h000000, 2'b11, "R5 both bit addends");
    run_a(16'h0000, 16'h0000, 24'h000000, 2'b01, "R5 single bit addend");
    run_a(16'hFFFF, 16'hFFFF, 24'hFFFFFF, 2'b11, "R6 all ones wrap");
    run_a(16'h00FF, 16'h00FF, 24'h0007FF, 2'b11, "R6 carry out of top dropped");

    for (int n = 0; n < 300; n++)
      run_a({pick8(), pick8()}, {pick8(), pick8()}, {12'($urandom), 12'($urandom)},
            2'($urandom), "R1 R2 R3 R4 R5 R6 random wide");

    // back-pressure on the registered stage
    xpa = 16'h80FF; xpb = 16'h7F81; xad = 24'h123ABC; xb = 2'b10;
    ypa = 16'h1234; ypb = 16'hFEDC; yad = 24'hFFF001; yb = 2'b01;
    @(negedge clk);
    a_pa = xpa; a_pb = xpb; a_ad = xad; a_bits = xb; a_iv = 1'b1; a_or = 1'b0;
    @(negedge clk);
    chk("R9 accepted beat valid", longint'(a_ov), 1);
    chk("R9 accepted beat result", longint'(a_res), longint'(exp_a(xpa, xpb, xad, xb)));
    a_pa = ypa; a_pb = ypb; a_ad = yad; a_bits = yb;
    #1;
    chk("R9 not ready while stalled", longint'(a_ir), 0);
    @(negedge clk);
    chk("R8 valid held under stall", longint'(a_ov), 1);
    chk("R8 result held under stall", longint'(a_res), longint'(exp_a(xpa, xpb, xad, xb)));
    a_or = 1'b1;
    #1;
    chk("R9 ready once consumer ready", longint'(a_ir), 1);
    @(negedge clk);
    chk("R9 next beat after release", longint'(a_res), longint'(exp_a(ypa, ypb, yad, yb)));
    a_iv = 1'b0;
    @(negedge clk);
    chk("R9 valid drops with no beat", longint'(a_ov), 0);

    // narrow combinational instance
    run_b(8'h00, 6'h00, 12'h000, 3'b000, "R7 narrow zero");
    run_b(8'h80, 6'h20, 12'h000, 3'b000, "R2 R3 narrow most negative pair");
    run_b(8'h7F, 6'h1F, 12'h000, 3'b000, "R2 R3 narrow most positive pair");
    run_b(8'h00, 6'h00, 12'hFFF, 3'b111, "R4 R5 R6 narrow wide addend and all bits");
    run_b(8'hFF, 6'h3F, 12'h3FF, 3'b101, "R6 narrow wrap");
    for (int n = 0; n < 300; n++)
      run_b(pick8(), 6'($urandom), 12'($urandom), 3'($urandom), "R2 R3 R4 R5 R6 random narrow");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule